// File: doc/BRIEF.md
# Interrupt Acknowledge Byte Feeder

This block sits in front of the data input of an 8-bit processor. In normal operation it returns bytes from a small local byte memory with synchronous read. While the processor signals an interrupt acknowledge, it instead supplies bytes from a 16-entry vector table fixed by a parameter. The processor can then execute a single-byte restart opcode or a longer instruction that arrives over several acknowledge fetches.

A table pointer steps forward once for each qualified read strobe during acknowledge. A qualified strobe has acknowledge, memory-request and read all high at one clock edge. The pointer steps before the first acknowledge byte is taken, so the sequence begins at index 1. Index 0 is only visible straight after reset. The pointer stops at the last index and does not wrap. The processor bus has fixed timing with no stall. No valid/ready handshake is used, and the block never applies back-pressure.

Top module: `ack_byte_feeder`

## Requirements
- R1: A synchronous active-high reset clears the pointer to 0. With acknowledge high and no strobe, the output then shows table entry 0.
- R2: A strobe (acknowledge, memory-request and read all 1 at a clock edge) advances the pointer by exactly one. The entry at the new index is on the output from the following cycle.
- R3: With acknowledge high but memory-request or read low, the pointer holds its value.
- R4: With acknowledge low, the pointer holds its value whatever memory-request and read do.
- R5: The pointer saturates at index 15. Further strobes leave entry 15 on the output.
- R6: The data output equals the table entry at the pointer while acknowledge is 1, and the memory read register while acknowledge is 0. It switches in the same cycle as acknowledge.
- R7: The memory read register loads the byte at the current address on every clock edge. When write is 1, the processor output byte is stored at that address.
- R8: A read in the same cycle as a write to the same address returns the contents held before that write.
- R9: Only address bits [10:0] select a memory byte, so address 0x0923 refers to the same byte as 0x0123.
- R10: The default table holds E7, 4F, 11, 34, 12 and 00 at indices 1 to 6, and 00 at every other index. Successive strobes therefore deliver E7, 4F, 11, 34, 12 in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| intack_i | input | 1 | Interrupt acknowledge from the processor |
| mreq_i | input | 1 | Valid memory access qualifier |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe for the byte memory |
| addr_i | input | 16 | Processor address |
| cpu_dout_i | input | 8 | Byte written by the processor |
| cpu_din_o | output | 8 | Byte delivered to the processor data input |

## Verification
The hardest case to reach is the interaction between the pointer and memory traffic that happens outside acknowledge. A strobe-like read with acknowledge low must not move the pointer. Because neighbouring table entries are often zero, such a step can go unnoticed. The stimulus therefore runs a second instance with a table of all-distinct values, issues non-acknowledge reads between acknowledge fetches, and checks after every cycle against a bench model of the pointer and memory. Saturation is reached by issuing twenty strobes in a row. Distinct values in entries 14 and 15 make a wrap or overshoot visible.

// File: rtl/ackfeed_pkg.sv
package ackfeed_pkg;
  localparam int unsigned TBL_ENTRIES = 16;
  localparam int unsigned BYTE_W      = 8;

  // index 0 sits in the low byte
  localparam logic [TBL_ENTRIES*BYTE_W-1:0] DEFAULT_TABLE =
    {72'h0, 8'h00, 8'h12, 8'h34, 8'h11, 8'h4F, 8'hE7, 8'h00};
endpackage

// File: rtl/ackfeed_ptr.sv
module ackfeed_ptr #(
  parameter int unsigned ENTRIES = ackfeed_pkg::TBL_ENTRIES,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             intack,
  input  logic             mreq,
  input  logic             rd,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic strobe;
  assign strobe = intack & mreq & rd;

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (strobe && ptr != LAST)
      ptr <= ptr + 1'b1;
  end

  // R2: a qualified strobe below the top index moves the pointer up by one
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (strobe && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

  // R2: the pointer never changes by anything other than a single step
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> (ptr == $past(ptr) + 1'b1));

  // R3, R4: without a full strobe the pointer does not move
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(ptr));

  // R5: once at the top index the pointer stays there
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (ptr == LAST) |=> (ptr == LAST));
endmodule

// File: rtl/ackfeed_vtab.sv
module ackfeed_vtab #(
  parameter int unsigned ENTRIES = ackfeed_pkg::TBL_ENTRIES,
  parameter int unsigned BYTE_W  = ackfeed_pkg::BYTE_W,
  parameter logic [ENTRIES*BYTE_W-1:0] TABLE = ackfeed_pkg::DEFAULT_TABLE,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic [PTR_W-1:0]  idx,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] entry [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign entry[g] = TABLE[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = entry[idx];
endmodule

// File: rtl/ackfeed_ram.sv
module ackfeed_ram #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BYTE_W = ackfeed_pkg::BYTE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // read first: the register takes the old contents when a write hits the same byte
  always_ff @(posedge clk) begin
    rdata <= mem[addr];
    if (we)
      mem[addr] <= wdata;
  end
endmodule

// File: rtl/ack_byte_feeder.sv
module ack_byte_feeder #(
  parameter int unsigned BUS_AW  = 16,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned ENTRIES = ackfeed_pkg::TBL_ENTRIES,
  parameter logic [ENTRIES*ackfeed_pkg::BYTE_W-1:0] TABLE = ackfeed_pkg::DEFAULT_TABLE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intack_i,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [7:0]        cpu_dout_i,
  output logic [7:0]        cpu_din_o
);
  localparam int unsigned PTR_W = $clog2(ENTRIES);

  logic [PTR_W-1:0] ptr;
  logic [7:0]       vec_byte;
  logic [7:0]       mem_q;
  logic             unused_hi_addr;

  assign unused_hi_addr = ^addr_i[BUS_AW-1:ADDR_W];

  ackfeed_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .intack (intack_i),
    .mreq   (mreq_i),
    .rd     (rd_i),
    .ptr    (ptr)
  );

  ackfeed_vtab #(.ENTRIES(ENTRIES), .BYTE_W(8), .TABLE(TABLE)) u_vtab (
    .idx    (ptr),
    .byte_o (vec_byte)
  );

  ackfeed_ram #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_ram (
    .clk   (clk),
    .addr  (addr_i[ADDR_W-1:0]),
    .we    (wr_i),
    .wdata (cpu_dout_i),
    .rdata (mem_q)
  );

  assign cpu_din_o = intack_i ? vec_byte : mem_q;
endmodule

// File: tb/ack_byte_feeder_tb.sv
`timescale 1ns/1ps
module ack_byte_feeder_tb;
  function automatic logic [127:0] alt_table();
    logic [127:0] t;
    for (int i = 0; i < 16; i++) t[i*8 +: 8] = 8'hA0 + 8'(i);
    return t;
  endfunction
  localparam logic [127:0] ALT_TABLE = alt_table();

  logic clk = 0;
  logic rst = 1;
  logic intack = 0, mreq = 0, rd = 0, wr = 0;
  logic [15:0] addr = '0;
  logic [7:0]  dout = '0;
  logic [7:0]  din_main, din_alt;

  always #5 clk = ~clk;

  ack_byte_feeder u_dut (
    .clk(clk), .rst(rst), .intack_i(intack), .mreq_i(mreq), .rd_i(rd),
    .wr_i(wr), .addr_i(addr), .cpu_dout_i(dout), .cpu_din_o(din_main));

  ack_byte_feeder #(.TABLE(ALT_TABLE)) u_alt (
    .clk(clk), .rst(rst), .intack_i(intack), .mreq_i(mreq), .rd_i(rd),
    .wr_i(wr), .addr_i(addr), .cpu_dout_i(dout), .cpu_din_o(din_alt));

  // bench model built from the requirements
  logic [7:0] tbl_main [16];
  logic [7:0] tbl_alt  [16];
  logic [7:0] mem_m [int];
  int         ptr_m = 0;
  logic [7:0] rdq_m = '0;
  bit         rdq_known = 0;

  // scoreboard
  logic [7:0] q_e0 [$];
  logic [7:0] q_e1 [$];
  bit         q_k  [$];
  string      q_r  [$];

  int checks = 0, fails = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      tbl_main[i] = 8'h00;
      tbl_alt[i]  = 8'hA0 + 8'(i);
    end
    // R10 default contents
    tbl_main[1] = 8'hE7; tbl_main[2] = 8'h4F; tbl_main[3] = 8'h11;
    tbl_main[4] = 8'h34; tbl_main[5] = 8'h12; tbl_main[6] = 8'h00;
  end

  task automatic model_edge(bit a, bit v, bit r, bit w, logic [15:0] ad, logic [7:0] d);
    int k = int'(ad[10:0]);  // R9: low eleven bits select the byte
    if (a && v && r && ptr_m < 15) ptr_m++;
    if (mem_m.exists(k)) begin rdq_m = mem_m[k]; rdq_known = 1; end
    else rdq_known = 0;
    if (w) mem_m[k] = d;
  endtask

  task automatic step(bit a, bit v, bit r, bit w, logic [15:0] ad, logic [7:0] d, string req);
    @(posedge clk); #2;
    intack = a; mreq = v; rd = r; wr = w; addr = ad; dout = d;
    if (a) begin
      q_e0.push_back(tbl_main[ptr_m]); q_e1.push_back(tbl_alt[ptr_m]); q_k.push_back(1);
    end else begin
      q_e0.push_back(rdq_m); q_e1.push_back(rdq_m); q_k.push_back(rdq_known);
    end
    q_r.push_back(req);
    model_edge(a, v, r, w, ad, d);
  endtask

  task automatic do_reset(int n);
    @(posedge clk); #2;
    rst = 1; intack = 0; mreq = 0; rd = 0; wr = 0;
    repeat (n) @(posedge clk);
    #2 rst = 0;
    ptr_m = 0; rdq_known = 0;
    // the cycle that begins here is still covered by the step that follows
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_r.size() > 0) begin
      logic [7:0] e0, e1; bit kn; string rq;
      e0 = q_e0.pop_front(); e1 = q_e1.pop_front(); kn = q_k.pop_front(); rq = q_r.pop_front();
      if (kn) begin
        checks += 2;
        if (din_main !== e0) begin
          fails++;
          $display("FAIL %s main: actual %h expected %h", rq, din_main, e0);
        end
        if (din_alt !== e1) begin
          fails++;
          $display("FAIL %s alt: actual %h expected %h", rq, din_alt, e1);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset(3);
    // R1: entry 0 after reset
    step(1,0,0,0,16'h0000,8'h00,"R1");
    // R7: write then read back
    step(0,1,0,1,16'h0055,8'h3C,"R7");
    step(0,1,1,0,16'h0055,8'h00,"R7");
    step(0,0,0,0,16'h0055,8'h00,"R7");
    // R8: read during write returns old data
    step(0,1,0,1,16'h0055,8'h99,"R8");
    step(0,1,1,0,16'h0055,8'h00,"R8");
    step(0,0,0,0,16'h0055,8'h00,"R8");
    // R9: aliasing of the upper address bits
    step(0,1,0,1,16'h0123,8'h5A,"R9");
    step(0,1,1,0,16'h0923,8'h00,"R9");
    step(0,0,0,0,16'h0923,8'h00,"R9");
    // R3: partial strobes during acknowledge
    step(1,1,0,0,16'h0000,8'h00,"R3");
    step(1,0,1,0,16'h0000,8'h00,"R3");
    step(1,0,0,0,16'h0000,8'h00,"R3");
    // R2: one strobe, entry 1 next cycle
    step(1,1,1,0,16'h0000,8'h00,"R2");
    step(1,0,0,0,16'h0000,8'h00,"R2");
    // R4: reads outside acknowledge do not move the pointer
    step(0,1,1,0,16'h0055,8'h00,"R4");
    step(0,1,1,0,16'h0055,8'h00,"R4");
    step(0,1,1,0,16'h0123,8'h00,"R4");
    step(1,0,0,0,16'h0000,8'h00,"R4");
    // R6: same-cycle switching of the source
    step(0,0,0,0,16'h0123,8'h00,"R6");
    step(1,0,0,0,16'h0123,8'h00,"R6");
    step(0,0,0,0,16'h0123,8'h00,"R6");
    // R10: stream the remaining bytes of the default sequence
    for (int i = 0; i < 5; i++) step(1,1,1,0,16'h0000,8'h00,"R10");
    step(1,0,0,0,16'h0000,8'h00,"R10");
    // R5: run past the end
    for (int i = 0; i < 20; i++) step(1,1,1,0,16'h0000,8'h00,"R5");
    step(1,0,0,0,16'h0000,8'h00,"R5");
    // R1: reset from a saturated pointer
    do_reset(2);
    step(1,0,0,0,16'h0000,8'h00,"R1");
    step(1,1,1,0,16'h0000,8'h00,"R1");
    step(1,0,0,0,16'h0000,8'h00,"R1");
    step(0,0,0,0,16'h0000,8'h00,"R1");
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule